// File: doc/BRIEF.md
# Sideband Request Header Formatter

This block sits between a requester and a sideband transaction engine. The requester hands over a single request. The request carries a 4-bit command code, a 16-bit target address, a payload length and, for writes, up to sixteen payload bytes. The formatter checks the request, packs a four-byte header, and streams the header and any write payload to the engine one byte per handshake. It then waits for the engine's reply: a status byte, a reported data length and the read data.

When the reply arrives, the formatter sorts the status into an error class or success. It works out the byte count that the requester should see, and masks read data past that count. It holds the result until the requester takes it. Requests that are too long or carry an unsupported command are turned back at once. No byte reaches the engine in either case. Only one request is in flight at any time.

Top module: `aux_hdr_fmt`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high. From then on `busy` is high and `req_ready` is low until the result is consumed (`res_valid` and `res_ready` both high), after which `busy` falls and the next request can be taken.
- R2: The transmitted frame begins with the address low byte, then the address high byte, then a byte whose bits 7:4 are the command code and whose bits 3:0 are zero.
- R3: Bits 3:0 of the fourth header byte carry the payload length minus one, or zero when the length is zero.
- R4: Bits 7:4 of the fourth header byte are 3 for a zero-length request. For a nonzero-length write they carry the low four bits of (4 + length), so length 12 gives 0 and length 16 gives 4. For a nonzero-length read they carry 4.
- R5: A write sends 4 + length bytes, with payload byte 0 (`req_data[7:0]`) directly after the header and the rest in ascending order. A read sends exactly 4 bytes. `tx_last` marks the final byte. While `tx_ready` is low, the offered byte and `tx_last` stay unchanged.
- R6: A request whose length exceeds 16 ends with result code 1 (too big) and sends no byte.
- R7: The command code is classified with its bit 2 ignored. Codes 0 and 8 are writes; codes 1 and 9 are reads. Any other code ends with result code 2 (invalid) and sends no byte.
- R8: A reply status of exactly 1, 2 or 3 gives result code 3 (timeout), 4 (busy) or 5 (I/O error) respectively, with count 0 and reply nibble 0. Any other status value gives result code 0 (success).
- R9: On success, a read reports the smaller of the reply length and the requested length, and a write reports the requested length.
- R10: On success, `res_reply` equals bits 7:4 of the reply status byte.
- R11: On a successful read, result data bytes below the reported count equal the reply data bytes. All other result data bytes are zero, and so is all result data after a write or an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Formatter can take a request |
| req_cmd | input | 4 | Command code; bit 0 read, bit 2 pass-through flag |
| req_addr | input | 16 | Target address |
| req_len | input | 6 | Payload length in bytes |
| req_data | input | 128 | Write payload, byte 0 in bits 7:0 |
| busy | output | 1 | A request is in flight |
| tx_valid | output | 1 | Frame byte offered to the engine |
| tx_ready | input | 1 | Engine takes the offered byte |
| tx_byte | output | 8 | Frame byte |
| tx_last | output | 1 | Offered byte is the last of the frame |
| rsp_valid | input | 1 | Engine reply present |
| rsp_ready | output | 1 | Formatter is waiting for the reply |
| rsp_status | input | 8 | Reply status byte |
| rsp_len | input | 6 | Data length reported by the engine |
| rsp_data | input | 128 | Reply data, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result held for the requester |
| res_ready | input | 1 | Requester takes the result |
| res_code | output | 3 | 0 ok, 1 too big, 2 invalid, 3 timeout, 4 busy, 5 I/O |
| res_count | output | 6 | Byte count returned |
| res_reply | output | 4 | Reply nibble |
| res_data | output | 128 | Read data, zeroed past the count |

## Verification
The bench targets the length nibble where it wraps. A write of twelve bytes must show 0 there and a write of sixteen must show 4. A design that kept the full sum or dropped the carry differently would send a wrong fourth header byte. The bench also covers bare-address requests. There, forgetting the forced value 3 would leave a zero or a four in the upper nibble. Read truncation is checked with a reply length both shorter and longer than the request. A missing minimum would report twenty bytes or expose stale data beyond the count. Finally, the bench sends an oversize request, a command with the pass-through flag set, an unsupported command and each failing status. A design that leaked bytes to the engine on a rejected request, or that classified status by its upper bits, would fail these checks.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;

    localparam int HDR_BYTES = 4;
    localparam logic [3:0] BARE_NIBBLE = 4'd3;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TOOBIG  = 3'd1,
        RES_INVAL   = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_BUSY    = 3'd4,
        RES_IO      = 3'd5
    } res_code_e;

    typedef enum logic [1:0] {
        KIND_WRITE,
        KIND_READ,
        KIND_BAD
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } fsm_e;

    typedef struct packed {
        res_code_e  code;
        logic [3:0] reply;
    } status_class_t;

    // Bit 2 is the pass-through flag and takes no part in classification.
    function automatic req_kind_e classify_cmd(input logic [3:0] cmd);
        logic [3:0] base;
        base = cmd & 4'b1011;
        case (base)
            4'h0, 4'h8: return KIND_WRITE;
            4'h1, 4'h9: return KIND_READ;
            default:    return KIND_BAD;
        endcase
    endfunction

    // Fourth header byte: size nibble on top, length-minus-one below.
    function automatic logic [7:0] len_field(input req_kind_e kind, input logic [7:0] len);
        logic [3:0] lo;
        logic [3:0] hi;
        logic [7:0] total;
        total = len + 8'(HDR_BYTES);
        lo    = (len == 8'd0) ? 4'd0 : 4'(len - 8'd1);
        if (len == 8'd0)
            hi = BARE_NIBBLE;
        else if (kind == KIND_WRITE)
            hi = total[3:0];
        else
            hi = 4'(HDR_BYTES);
        return {hi, lo};
    endfunction

    function automatic status_class_t classify_status(input logic [7:0] st);
        status_class_t r;
        r.reply = st[7:4];
        case (st)
            8'd1:    r.code = RES_TIMEOUT;
            8'd2:    r.code = RES_BUSY;
            8'd3:    r.code = RES_IO;
            default: r.code = RES_OK;
        endcase
        if (r.code != RES_OK)
            r.reply = 4'd0;
        return r;
    endfunction

endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
    import aux_fmt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 6,
    parameter int IDX_W  = 5
) (
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  req_kind_e         kind,
    output logic [31:0]       hdr,
    output logic [IDX_W-1:0]  total
);

    always_comb begin
        hdr[7:0]   = addr[7:0];
        hdr[15:8]  = 8'(addr >> 8);
        hdr[23:16] = {cmd, 4'h0};
        hdr[31:24] = len_field(kind, 8'(len));
        if (kind == KIND_WRITE)
            total = IDX_W'(HDR_BYTES) + IDX_W'(len);
        else
            total = IDX_W'(HDR_BYTES);
    end

endmodule

// File: rtl/aux_tx_stream.sv
module aux_tx_stream
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int IDX_W       = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     active,
    input  logic [31:0]              hdr,
    input  logic [MAX_PAYLOAD*8-1:0] payload,
    input  logic [IDX_W-1:0]         total,
    input  logic                     tx_ready,
    output logic                     tx_valid,
    output logic [7:0]               tx_byte,
    output logic                     tx_last,
    output logic                     done
);

    localparam int NBYTES = HDR_BYTES + MAX_PAYLOAD;

    logic [7:0]       frame [NBYTES];
    logic [IDX_W-1:0] idx_q;

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
        assign frame[g] = hdr[g*8 +: 8];
    end
    for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_pay
        assign frame[HDR_BYTES+g] = payload[g*8 +: 8];
    end

    always_comb begin
        tx_byte = 8'h00;
        for (int i = 0; i < NBYTES; i++)
            if (idx_q == IDX_W'(i))
                tx_byte = frame[i];
    end

    assign tx_valid = active;
    assign tx_last  = active && (idx_q == total - IDX_W'(1));
    assign done     = active && tx_ready && tx_last;

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx_q <= '0;
        else if (active && tx_ready && !tx_last)
            idx_q <= idx_q + IDX_W'(1);
    end

    // R5: a stalled byte is held unchanged.
    assert_hold_stalled_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

    // R5: the byte index never runs past the frame size.
    assert_idx_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (idx_q < total));

endmodule

// File: rtl/aux_rsp_decode.sv
module aux_rsp_decode
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int LEN_W       = 6
) (
    input  logic [7:0]               status,
    input  logic [LEN_W-1:0]         rsp_len,
    input  logic [MAX_PAYLOAD*8-1:0] rsp_data,
    input  req_kind_e                kind,
    input  logic [LEN_W-1:0]         req_len,
    output res_code_e                code,
    output logic [LEN_W-1:0]         count,
    output logic [3:0]               reply,
    output logic [MAX_PAYLOAD*8-1:0] data
);

    status_class_t sc;

    always_comb begin
        sc    = classify_status(status);
        code  = sc.code;
        reply = sc.reply;
        if (sc.code != RES_OK)
            count = '0;
        else if (kind == KIND_READ)
            count = (rsp_len < req_len) ? rsp_len : req_len;
        else
            count = req_len;
    end

    for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_mask
        assign data[g*8 +: 8] =
            (code == RES_OK && kind == KIND_READ && LEN_W'(g) < count)
            ? rsp_data[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/aux_hdr_fmt.sv
module aux_hdr_fmt
    import aux_fmt_pkg::*;
#(
    parameter  int ADDR_W      = 16,
    parameter  int MAX_PAYLOAD = 16,
    localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1) + 1,
    localparam int DATA_W      = MAX_PAYLOAD * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [7:0]        rsp_status,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [2:0]        res_code,
    output logic [LEN_W-1:0]  res_count,
    output logic [3:0]        res_reply,
    output logic [DATA_W-1:0] res_data
);

    localparam int IDX_W = $clog2(MAX_PAYLOAD + HDR_BYTES + 1);

    fsm_e              state_q;
    logic [3:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] data_q;
    req_kind_e         kind_q;
    res_code_e         code_q;
    logic [LEN_W-1:0]  count_q;
    logic [3:0]        reply_q;
    logic [DATA_W-1:0] rdata_q;

    logic [31:0]       hdr;
    logic [IDX_W-1:0]  total;
    logic              tx_done;
    req_kind_e         in_kind;
    res_code_e         dec_code;
    logic [LEN_W-1:0]  dec_count;
    logic [3:0]        dec_reply;
    logic [DATA_W-1:0] dec_data;

    assign in_kind = classify_cmd(req_cmd);

    aux_hdr_pack #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) i_pack (
        .cmd(cmd_q), .addr(addr_q), .len(len_q), .kind(kind_q),
        .hdr(hdr), .total(total)
    );

    aux_tx_stream #(
        .MAX_PAYLOAD(MAX_PAYLOAD), .IDX_W(IDX_W)
    ) i_stream (
        .clk(clk), .rst(rst), .clr(state_q == ST_IDLE),
        .active(state_q == ST_SEND), .hdr(hdr), .payload(data_q),
        .total(total), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last), .done(tx_done)
    );

    aux_rsp_decode #(
        .MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W)
    ) i_decode (
        .status(rsp_status), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .kind(kind_q), .req_len(len_q), .code(dec_code),
        .count(dec_count), .reply(dec_reply), .data(dec_data)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign rsp_ready = (state_q == ST_WAIT);
    assign res_valid = (state_q == ST_DONE);
    assign res_code  = code_q;
    assign res_count = count_q;
    assign res_reply = reply_q;
    assign res_data  = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            data_q  <= '0;
            kind_q  <= KIND_WRITE;
            code_q  <= RES_OK;
            count_q <= '0;
            reply_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    cmd_q  <= req_cmd;
                    addr_q <= req_addr;
                    len_q  <= req_len;
                    data_q <= req_data;
                    kind_q <= in_kind;
                    if (req_len > LEN_W'(MAX_PAYLOAD) || in_kind == KIND_BAD) begin
                        code_q  <= (req_len > LEN_W'(MAX_PAYLOAD)) ? RES_TOOBIG : RES_INVAL;
                        count_q <= '0;
                        reply_q <= '0;
                        rdata_q <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: if (tx_done) state_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    code_q  <= dec_code;
                    count_q <= dec_count;
                    reply_q <= dec_reply;
                    rdata_q <= dec_data;
                    state_q <= ST_DONE;
                end
                ST_DONE: if (res_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: an accepted request makes the block busy on the next cycle.
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    // R1: busy only drops after the result has been handed over.
    assert_release_on_result_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(res_valid && res_ready));

    // R6: no byte leaves for an oversize request.
    assert_no_tx_oversize_R6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (len_q <= LEN_W'(MAX_PAYLOAD)));

    // R7: no byte leaves for an unsupported command.
    assert_no_tx_badcmd_R7: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (kind_q != KIND_BAD));

    // R8: every error result carries a zero count and zero reply nibble.
    assert_err_zero_count_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code != RES_OK) |-> (res_count == '0 && res_reply == 4'd0));

    // R9: a successful count never exceeds the requested length.
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code == RES_OK) |-> (res_count <= len_q));

endmodule

// File: tb/test_aux_hdr_fmt.sv
module test_aux_hdr_fmt;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_cmd = '0;
    logic [15:0]  req_addr = '0;
    logic [5:0]   req_len = '0;
    logic [127:0] req_data = '0;
    logic         busy;
    logic         tx_valid;
    logic         tx_ready = 1'b1;
    logic [7:0]   tx_byte;
    logic         tx_last;
    logic         rsp_valid = 1'b0;
    logic         rsp_ready;
    logic [7:0]   rsp_status = '0;
    logic [5:0]   rsp_len = '0;
    logic [127:0] rsp_data = '0;
    logic         res_valid;
    logic         res_ready = 1'b0;
    logic [2:0]   res_code;
    logic [5:0]   res_count;
    logic [3:0]   res_reply;
    logic [127:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]   got [0:31];
    int           ngot;
    bit           hold_ok;
    bit           last_ok;
    bit           bp;
    logic [2:0]   r_code;
    logic [5:0]   r_count;
    logic [3:0]   r_reply;
    logic [127:0] r_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_hdr_fmt i_aux_hdr_fmt (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .req_data(req_data), .busy(busy), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_last(tx_last),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_len(rsp_len), .rsp_data(rsp_data), .res_valid(res_valid),
        .res_ready(res_ready), .res_code(res_code), .res_count(res_count),
        .res_reply(res_reply), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_write(input logic [3:0] cmd);
        return ((cmd & 4'hB) == 4'h0) || ((cmd & 4'hB) == 4'h8);
    endfunction

    function automatic logic [7:0] exp_b3(input logic [3:0] cmd, input int len);
        logic [3:0] hi;
        logic [3:0] lo;
        lo = (len == 0) ? 4'd0 : 4'(len - 1);
        if (len == 0)           hi = 4'd3;
        else if (is_write(cmd)) hi = 4'((4 + len) % 16);
        else                    hi = 4'd4;
        return {hi, lo};
    endfunction

    task automatic transact(input logic [3:0] cmd, input logic [15:0] addr,
                            input int len, input logic [127:0] data,
                            input logic [7:0] st, input int rlen,
                            input logic [127:0] rdata);
        ngot = 0; hold_ok = 1; last_ok = 1;
        @(negedge clk);
        req_cmd = cmd; req_addr = addr; req_len = 6'(len); req_data = data;
        rsp_status = st; rsp_len = 6'(rlen); rsp_data = rdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (res_valid) break;
            tx_ready  = bp ? k[0] : 1'b1;
            rsp_valid = rsp_ready;
            if (!busy || req_ready) hold_ok = 0;
            if (tx_valid && tx_ready) begin
                if (ngot < 32) got[ngot] = tx_byte;
                ngot++;
                if (tx_last != (ngot == (is_write(cmd) ? 4 + len : 4))) last_ok = 0;
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0; tx_ready = 1'b1;
        r_code = res_code; r_count = res_count; r_reply = res_reply; r_data = res_data;
        chk(res_valid == 1'b1, "R1 result offered", 128'(res_valid), 128'd1);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!busy && req_ready, "R1 released after result", 128'(busy), 128'd0);
    endtask

    task automatic check_frame(input logic [3:0] cmd, input logic [15:0] addr,
                               input int len, input logic [127:0] data);
        int  n;
        bit  ok;
        n  = is_write(cmd) ? 4 + len : 4;
        chk(ngot == n, "R5 frame length", 128'(ngot), 128'(n));
        if (ngot == n) begin
            chk(got[0] == addr[7:0] && got[1] == addr[15:8] && got[2] == {cmd, 4'h0},
                "R2 header bytes", {got[0], got[1], got[2]}, {addr[7:0], addr[15:8], cmd, 4'h0});
            chk(got[3] == exp_b3(cmd, len), "R3 R4 length byte",
                128'(got[3]), 128'(exp_b3(cmd, len)));
            ok = 1;
            for (int i = 4; i < n; i++)
                if (got[i] != data[(i-4)*8 +: 8]) ok = 0;
            chk(ok, "R5 payload order", 128'(ok), 128'd1);
        end
        chk(last_ok, "R5 last marker", 128'(last_ok), 128'd1);
        chk(hold_ok, "R1 busy and not ready in flight", 128'(hold_ok), 128'd1);
    endtask

    task automatic t_reset();
        chk(!busy && req_ready, "R1 reset idle", 128'(busy), 128'd0);
        chk(!tx_valid && !res_valid && !rsp_ready, "R1 reset outputs quiet",
            128'({tx_valid, res_valid, rsp_ready}), 128'd0);
    endtask

    task automatic t_native_write();
        logic [127:0] d = 128'h00000000_00000000_00000000_00C3B2A1;
        transact(4'h8, 16'h1234, 3, d, 8'h00, 0, '0);
        check_frame(4'h8, 16'h1234, 3, d);
        chk(r_code == 3'd0 && r_count == 6'd3, "R9 write count", 128'(r_count), 128'd3);
        chk(r_reply == 4'd0, "R10 reply nibble", 128'(r_reply), 128'd0);
        chk(r_data == '0, "R11 write data zero", r_data, '0);
    endtask

    task automatic t_bare_write();
        transact(4'h8, 16'hBEEF, 0, '0, 8'h10, 0, '0);
        check_frame(4'h8, 16'hBEEF, 0, '0);
        chk(r_code == 3'd0 && r_count == 6'd0, "R9 bare write count", 128'(r_count), 128'd0);
        chk(r_reply == 4'd1, "R10 reply nibble bare", 128'(r_reply), 128'd1);
    endtask

    task automatic t_read_trunc();
        logic [127:0] rd = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
        transact(4'h9, 16'h0200, 4, '0, 8'h00, 2, rd);
        check_frame(4'h9, 16'h0200, 4, '0);
        chk(r_count == 6'd2, "R9 read min count", 128'(r_count), 128'd2);
        chk(r_data == 128'h1100, "R11 read data masked", r_data, 128'h1100);
    endtask

    task automatic t_i2c_read_flag();
        logic [127:0] rd = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        transact(4'h5, 16'h0050, 16, '0, 8'h20, 20, rd);
        check_frame(4'h5, 16'h0050, 16, '0);
        chk(r_code == 3'd0 && r_count == 6'd16, "R7 R9 flagged read count", 128'(r_count), 128'd16);
        chk(r_reply == 4'd2, "R10 reply nibble read", 128'(r_reply), 128'd2);
        chk(r_data == rd, "R11 full read data", r_data, rd);
        transact(4'h9, 16'h0051, 0, '0, 8'h00, 5, rd);
        check_frame(4'h9, 16'h0051, 0, '0);
        chk(r_count == 6'd0 && r_data == '0, "R11 bare read nothing", 128'(r_count), 128'd0);
    endtask

    task automatic t_wrap_nibble();
        logic [127:0] d = 128'h100F0E0D_0C0B0A09_08070605_04030201;
        bp = 1;
        transact(4'h0, 16'h00A0, 12, d, 8'h00, 0, '0);
        check_frame(4'h0, 16'h00A0, 12, d);
        chk(r_count == 6'd12, "R9 write 12 count", 128'(r_count), 128'd12);
        transact(4'h4, 16'h00A1, 16, d, 8'h00, 0, '0);
        check_frame(4'h4, 16'h00A1, 16, d);
        chk(r_count == 6'd16, "R9 write 16 count", 128'(r_count), 128'd16);
        bp = 0;
    endtask

    task automatic t_too_big();
        transact(4'h8, 16'h0001, 17, '1, 8'h00, 0, '0);
        chk(ngot == 0, "R6 no bytes sent", 128'(ngot), 128'd0);
        chk(r_code == 3'd1 && r_count == 6'd0, "R6 too big code", 128'(r_code), 128'd1);
    endtask

    task automatic t_invalid();
        transact(4'h2, 16'h0002, 1, '0, 8'h00, 0, '0);
        chk(ngot == 0, "R7 no bytes for bad command", 128'(ngot), 128'd0);
        chk(r_code == 3'd2, "R7 invalid code", 128'(r_code), 128'd2);
        transact(4'hA, 16'h0003, 0, '0, 8'h00, 0, '0);
        chk(ngot == 0 && r_code == 3'd2, "R7 invalid code 0xA", 128'(r_code), 128'd2);
    endtask

    task automatic t_status_errors();
        for (int s = 1; s <= 3; s++) begin
            transact(4'h9, 16'h0300, 4, '0, 8'(s), 4, '1);
            chk(r_code == 3'(s + 2), "R8 status class", 128'(r_code), 128'(s + 2));
            chk(r_count == 6'd0 && r_reply == 4'd0 && r_data == '0, "R8 error zeroes",
                128'(r_count), 128'd0);
        end
        transact(4'h9, 16'h0300, 4, '0, 8'h13, 4, 128'hAABBCCDD);
        chk(r_code == 3'd0 && r_reply == 4'd1, "R8 R10 upper bits are not an error",
            128'(r_code), 128'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        bp = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_native_write();
        t_bare_write();
        t_read_trunc();
        t_i2c_read_flag();
        t_wrap_nibble();
        t_too_big();
        t_invalid();
        t_status_errors();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule